// File: doc/BRIEF.md
# Serial Audio Master Clock Generator

This block sits next to a serial audio port that runs as clock master. It runs entirely on a high-rate master clock. From that clock it derives a bit clock at 64 times the sample rate and a left/right frame clock with 32 bit-clock periods per channel. It also provides a clock output that either repeats the master clock or is held low. A two-bit rate field sets how many master-clock cycles make up one sample period. A format bit sets the frame-clock polarity: inter-IC sound (left channel low) or the justified convention (left channel high). A hold bit parks both serial clocks at fixed levels.

All settings sit in one configuration byte, written with a single-cycle strobe. The byte is accepted only while the active-low system reset is held. A separate active-low power-on reset returns the byte to 00h. While the system reset is held, the serial clocks rest at their idle levels. When it is released, generation starts cleanly at the first bit of a left-channel frame.

The sequencer has three states. ST_CONFIG is entered on power-on reset and whenever the system reset is low. ST_RUN clocks the dividers. ST_FROZEN parks the clocks. The transitions are named as follows. "start" goes from ST_CONFIG to ST_RUN on release with hold clear. "park" goes from ST_CONFIG to ST_FROZEN on release with hold set. "stop" goes from ST_RUN to ST_CONFIG when the system reset is asserted. "unpark" goes from ST_FROZEN to ST_CONFIG when the system reset is asserted.

Top module: `audio_clkgen`

## Requirements
- R1: Byte bits 7:6 select the master-to-sample ratio: 00=512, 01=1536, 10=2048 and 11=3072 master cycles per frame. The bit-clock period is therefore 8, 24, 32 or 48 master cycles.
- R2: In each bit-clock period the bit clock is low for the first half and high for the second half. The frame clock changes only together with a falling edge of the bit clock. Each frame holds 32 bit periods of left channel followed by 32 bit periods of right channel.
- R3: Byte bit 5 selects the frame-clock polarity. With bit 5 = 0 the frame clock is high for the left channel. With bit 5 = 1 (inter-IC sound) it is low for the left channel.
- R4: A configuration write is captured only on a master-clock edge at which the system reset is low. A write while the system reset is high leaves the configuration and all outputs unaffected.
- R5: With byte bit 2 = 1, releasing the system reset parks the bit clock low. The frame clock is parked high when bit 5 = 0 and low when bit 5 = 1.
- R6: With byte bit 1 = 0 the clock output follows the master clock. With bit 1 = 1 it is driven low. A new value applies from the master-clock edge that captures the write.
- R7: Power-on reset sets the configuration to 00h. Byte bits 4, 3 and 0 have no effect on any output.
- R8: While the system reset is low, the bit clock is low and the frame clock sits at its left-channel level. After the first master edge with the system reset high, the outputs show cycle 0 of a left frame. The bit clock rises after the next half-period count of edges.
- R9: After a frozen period, passing through the system reset with bit 2 cleared resumes generation at the first bit of a new left frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mst | input | 1 | High-rate master clock; clocks all logic |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| sys_rst_n | input | 1 | Active-low system reset; opens the configuration window |
| cfg_wr | input | 1 | Single-cycle configuration write strobe |
| cfg_byte | input | 8 | Configuration byte |
| bclk | output | 1 | Bit clock, 64 periods per frame |
| lrclk | output | 1 | Left/right frame clock |
| clk_out | output | 1 | Master clock repeated, or held low |

## Verification
The reference model in the bench walks through every ratio, both polarities and both park levels. It compares both serial clocks on every master cycle, so an off-by-one divider or a frame-clock edge placed one master cycle away from the bit-clock fall is caught. The bench writes a byte while the system reset is high. A design that leaked that write would stop the clock output or change the bit-clock period. Each release of the system reset is checked on its first edge and on the half-period edge, which catches dividers that do not restart from zero. Writes carrying only the unused bits must leave the default timing intact. A clock-output write must act on its own capture edge and not one cycle later.

// File: rtl/audio_clkgen_pkg.sv
package audio_clkgen_pkg;

    typedef enum logic [1:0] {
        ST_CONFIG = 2'd0,
        ST_RUN    = 2'd1,
        ST_FROZEN = 2'd2
    } gen_state_e;

    typedef struct packed {
        logic [1:0] rate_sel;
        logic       fmt_i2s;
        logic       hold_clks;
        logic       cko_off;
    } gen_cfg_t;

    localparam gen_cfg_t CFG_DEFAULT = '0;

endpackage

// File: rtl/audio_clkgen_cfg.sv
module audio_clkgen_cfg
    import audio_clkgen_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sys_rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_byte,
    output gen_cfg_t   cfg_q,
    output logic       lr_idle_nxt
);

    gen_cfg_t cfg_nxt;
    gen_cfg_t wr_fields;
    logic     unused_rsvd_bits;

    assign unused_rsvd_bits = ^{wr_byte[4:3], wr_byte[0]};

    always_comb begin
        wr_fields.rate_sel  = wr_byte[7:6];
        wr_fields.fmt_i2s   = wr_byte[5];
        wr_fields.hold_clks = wr_byte[2];
        wr_fields.cko_off   = wr_byte[1];
    end

    // the write window is open only while the system reset is held
    always_comb begin
        cfg_nxt     = (!sys_rst_n && wr_en) ? wr_fields : cfg_q;
        lr_idle_nxt = ~cfg_nxt.fmt_i2s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= CFG_DEFAULT;
        end else begin
            cfg_q <= cfg_nxt;
        end
    end

endmodule

// File: rtl/audio_clkgen_fsm.sv
module audio_clkgen_fsm
    import audio_clkgen_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sys_rst_n,
    input  logic       hold_clks,
    output gen_state_e state_q,
    output logic       adv
);

    gen_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CONFIG: begin
                if (sys_rst_n) begin
                    state_d = hold_clks ? ST_FROZEN : ST_RUN;
                end
            end
            ST_RUN: begin
                if (!sys_rst_n) begin
                    state_d = ST_CONFIG;
                end
            end
            ST_FROZEN: begin
                if (!sys_rst_n) begin
                    state_d = ST_CONFIG;
                end
            end
            default: state_d = ST_CONFIG;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CONFIG;
        end else begin
            state_q <= state_d;
        end
    end

    // dividers advance only on edges that keep the sequencer running
    always_comb begin
        adv = (state_q == ST_RUN) && (state_d == ST_RUN);
    end

endmodule

// File: rtl/audio_clkgen_div.sv
module audio_clkgen_div #(
    parameter int unsigned BITS_PER_CH = 32,
    parameter int unsigned RATIO_0     = 512,
    parameter int unsigned RATIO_1     = 1536,
    parameter int unsigned RATIO_2     = 2048,
    parameter int unsigned RATIO_3     = 3072
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adv,
    input  logic [1:0] rate_sel,
    input  logic       fmt_i2s,
    input  logic       lr_idle_nxt,
    output logic       bclk,
    output logic       lrclk
);

    localparam int unsigned FRAME_BITS = 2 * BITS_PER_CH;
    localparam int unsigned RATIO_TAB [4] = '{RATIO_0, RATIO_1, RATIO_2, RATIO_3};
    localparam int unsigned MAX_01  = (RATIO_0 > RATIO_1) ? RATIO_0 : RATIO_1;
    localparam int unsigned MAX_23  = (RATIO_2 > RATIO_3) ? RATIO_2 : RATIO_3;
    localparam int unsigned MAX_DIV = ((MAX_01 > MAX_23) ? MAX_01 : MAX_23) / FRAME_BITS;
    localparam int unsigned PH_W    = $clog2(MAX_DIV);
    localparam int unsigned BIT_W   = $clog2(FRAME_BITS);

    logic [PH_W-1:0]  last_tab [4];
    logic [PH_W-1:0]  mid_tab  [4];
    logic [PH_W-1:0]  ph_last_val;
    logic [PH_W-1:0]  ph_mid_val;
    logic [PH_W-1:0]  ph_q;
    logic [BIT_W-1:0] bit_q;
    logic [BIT_W-1:0] bit_n;
    logic             ph_last;
    logic             ph_mid;
    logic             left_lvl;
    logic             bclk_q;
    logic             lr_q;

    for (genvar g = 0; g < 4; g++) begin : g_div_tab
        assign last_tab[g] = PH_W'(RATIO_TAB[g] / FRAME_BITS - 1);
        assign mid_tab[g]  = PH_W'(RATIO_TAB[g] / FRAME_BITS / 2 - 1);
    end

    always_comb begin
        ph_last_val = last_tab[rate_sel];
        ph_mid_val  = mid_tab[rate_sel];
        ph_last     = (ph_q == ph_last_val);
        ph_mid      = (ph_q == ph_mid_val);
        left_lvl    = ~fmt_i2s;
        bit_n       = (bit_q == BIT_W'(FRAME_BITS - 1)) ? '0 : bit_q + BIT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q  <= '0;
            bit_q <= '0;
        end else if (!adv) begin
            ph_q  <= '0;
            bit_q <= '0;
        end else begin
            ph_q <= ph_last ? '0 : ph_q + PH_W'(1);
            if (ph_last) begin
                bit_q <= bit_n;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_q <= 1'b0;
            lr_q   <= 1'b1;
        end else if (!adv) begin
            bclk_q <= 1'b0;
            lr_q   <= lr_idle_nxt;
        end else begin
            if (ph_mid) begin
                bclk_q <= 1'b1;
            end else if (ph_last) begin
                bclk_q <= 1'b0;
            end
            if (ph_last) begin
                lr_q <= (bit_n < BIT_W'(BITS_PER_CH)) ? left_lvl : ~left_lvl;
            end
        end
    end

    assign bclk  = bclk_q;
    assign lrclk = lr_q;

endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
    import audio_clkgen_pkg::*;
#(
    parameter int unsigned BITS_PER_CH = 32,
    parameter int unsigned RATIO_0     = 512,
    parameter int unsigned RATIO_1     = 1536,
    parameter int unsigned RATIO_2     = 2048,
    parameter int unsigned RATIO_3     = 3072
) (
    input  logic       clk_mst,
    input  logic       rst_n,
    input  logic       sys_rst_n,
    input  logic       cfg_wr,
    input  logic [7:0] cfg_byte,
    output logic       bclk,
    output logic       lrclk,
    output logic       clk_out
);

    gen_cfg_t   cfg_q;
    gen_state_e state_q;
    logic       lr_idle_nxt;
    logic       adv;

    audio_clkgen_cfg u_cfg (
        .clk         (clk_mst),
        .rst_n       (rst_n),
        .sys_rst_n   (sys_rst_n),
        .wr_en       (cfg_wr),
        .wr_byte     (cfg_byte),
        .cfg_q       (cfg_q),
        .lr_idle_nxt (lr_idle_nxt)
    );

    audio_clkgen_fsm u_fsm (
        .clk       (clk_mst),
        .rst_n     (rst_n),
        .sys_rst_n (sys_rst_n),
        .hold_clks (cfg_q.hold_clks),
        .state_q   (state_q),
        .adv       (adv)
    );

    audio_clkgen_div #(
        .BITS_PER_CH (BITS_PER_CH),
        .RATIO_0     (RATIO_0),
        .RATIO_1     (RATIO_1),
        .RATIO_2     (RATIO_2),
        .RATIO_3     (RATIO_3)
    ) u_div (
        .clk         (clk_mst),
        .rst_n       (rst_n),
        .adv         (adv),
        .rate_sel    (cfg_q.rate_sel),
        .fmt_i2s     (cfg_q.fmt_i2s),
        .lr_idle_nxt (lr_idle_nxt),
        .bclk        (bclk),
        .lrclk       (lrclk)
    );

    assign clk_out = clk_mst & ~cfg_q.cko_off;

endmodule

// File: rtl/audio_clkgen_chk.sv
module audio_clkgen_chk
    import audio_clkgen_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       sys_rst_n,
    input logic       bclk,
    input logic       lrclk,
    input logic       clk_out,
    input logic       fmt_i2s,
    input logic       cko_off,
    input logic [4:0] cfg_bits,
    input gen_state_e state_q
);

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_rst_n |=> (!bclk && (lrclk == !fmt_i2s)));

    p_cfg_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_n |=> $stable(cfg_bits));

    p_park_levels_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FROZEN) |-> (!bclk && (lrclk == !fmt_i2s)));

    p_lr_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RUN) && ($past(state_q) == ST_RUN) && (lrclk != $past(lrclk)))
        |-> $fell(bclk));

    p_left_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RUN) && ($past(state_q) != ST_RUN))
        |-> (!bclk && (lrclk == !fmt_i2s)));

    always_comb begin
        p_cko_low_r6: assert (!(cko_off && clk_out));
    end

endmodule

bind audio_clkgen audio_clkgen_chk u_chk (
    .clk       (clk_mst),
    .rst_n     (rst_n),
    .sys_rst_n (sys_rst_n),
    .bclk      (bclk),
    .lrclk     (lrclk),
    .clk_out   (clk_out),
    .fmt_i2s   (cfg_q.fmt_i2s),
    .cko_off   (cfg_q.cko_off),
    .cfg_bits  (cfg_q),
    .state_q   (state_q)
);

// File: tb/audio_clkgen_tb.sv
module audio_clkgen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sys_rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_byte = 8'h00;
    logic       bclk;
    logic       lrclk;
    logic       clk_out;

    int n_tests = 0;
    int n_fail  = 0;

    // reference model state
    logic [7:0] m_cfg = 8'h00;
    bit         m_run = 1'b0;
    bit         m_frz = 1'b0;
    int         m_k   = 0;

    always #10 clk = ~clk;

    audio_clkgen u_dut (
        .clk_mst   (clk),
        .rst_n     (rst_n),
        .sys_rst_n (sys_rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_byte  (cfg_byte),
        .bclk      (bclk),
        .lrclk     (lrclk),
        .clk_out   (clk_out)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int bit_period(input logic [1:0] sel);
        int ratio;
        case (sel)
            2'd0:    ratio = 512;
            2'd1:    ratio = 1536;
            2'd2:    ratio = 2048;
            default: ratio = 3072;
        endcase
        return ratio / 64;
    endfunction

    // model update on each edge, comparison in the high phase
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cfg = 8'h00;
            m_run = 1'b0;
            m_frz = 1'b0;
            m_k   = 0;
        end else if (!sys_rst_n) begin
            if (cfg_wr) m_cfg = cfg_byte;
            m_run = 1'b0;
            m_frz = 1'b0;
        end else if (!m_run && !m_frz) begin
            if (m_cfg[2]) begin
                m_frz = 1'b1;
            end else begin
                m_run = 1'b1;
                m_k   = 0;
            end
        end else if (m_run) begin
            m_k++;
        end
        #5;
        if (rst_n) begin
            int  d;
            bit  left;
            bit  eb;
            bit  el;
            d    = bit_period(m_cfg[7:6]);
            left = ~m_cfg[5];
            if (m_run) begin
                eb = (m_k % d) >= (d / 2);
                el = (((m_k / d) % 64) < 32) ? left : ~left;
                chk(bclk == eb, "R1", "bclk", int'(bclk), int'(eb));
                chk(lrclk == el, "R2", "lrclk", int'(lrclk), int'(el));
            end else if (m_frz) begin
                chk(bclk == 1'b0, "R5", "bclk parked", int'(bclk), 0);
                chk(lrclk == left, "R5", "lrclk parked", int'(lrclk), int'(left));
            end else begin
                chk(bclk == 1'b0, "R8", "bclk idle", int'(bclk), 0);
                chk(lrclk == left, "R8", "lrclk idle", int'(lrclk), int'(left));
            end
            chk(clk_out == ~m_cfg[1], "R6", "clk_out high phase", int'(clk_out), int'(~m_cfg[1]));
        end
    end

    always @(negedge clk) begin
        #5;
        if (rst_n) chk(clk_out == 1'b0, "R6", "clk_out low phase", int'(clk_out), 0);
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load_cfg(input logic [7:0] b);
        @(negedge clk);
        sys_rst_n = 1'b0;
        cyc(2);
        cfg_wr   = 1'b1;
        cfg_byte = b;
        @(posedge clk);
        #5;
        chk(clk_out == ~b[1], "R6", "clk_out on capture edge", int'(clk_out), int'(~b[1]));
        @(negedge clk);
        cfg_wr = 1'b0;
        cyc(2);
    endtask

    // valid for ratio code 00 only (half period of 4 master cycles)
    task automatic release_chk(input bit frz, input bit left, input string tag);
        sys_rst_n = 1'b1;
        @(posedge clk);
        #5;
        chk(bclk == 1'b0, tag, "bclk first edge", int'(bclk), 0);
        chk(lrclk == left, tag, "lrclk first edge", int'(lrclk), int'(left));
        repeat (4) @(posedge clk);
        #5;
        chk(bclk == !frz, tag, "bclk after half period", int'(bclk), int'(!frz));
        @(negedge clk);
    endtask

    initial begin
        #15;
        chk(bclk == 1'b0, "R7", "bclk in power-on reset", int'(bclk), 0);
        chk(lrclk == 1'b1, "R7", "lrclk in power-on reset", int'(lrclk), 1);
        chk(clk_out == 1'b1, "R7", "clk_out in power-on reset", int'(clk_out), 1);
        @(negedge clk);
        rst_n = 1'b1;
        cyc(2);
        release_chk(1'b0, 1'b1, "R8");
        cyc(1100);

        // write while running must be ignored (R4)
        cfg_wr   = 1'b1;
        cfg_byte = 8'hC6;
        @(posedge clk);
        #5;
        chk(clk_out == 1'b1, "R4", "clk_out after ignored write", int'(clk_out), 1);
        @(negedge clk);
        cfg_wr = 1'b0;
        cyc(600);

        load_cfg(8'h40); sys_rst_n = 1'b1; cyc(3300);
        load_cfg(8'h80); sys_rst_n = 1'b1; cyc(4200);
        load_cfg(8'hC0); sys_rst_n = 1'b1; cyc(6300);

        load_cfg(8'h20); release_chk(1'b0, 1'b0, "R3"); cyc(1100);
        load_cfg(8'h19); release_chk(1'b0, 1'b1, "R7"); cyc(600);
        load_cfg(8'h04); release_chk(1'b1, 1'b1, "R5"); cyc(300);
        load_cfg(8'h24); release_chk(1'b1, 1'b0, "R5"); cyc(300);
        load_cfg(8'h00); release_chk(1'b0, 1'b1, "R9"); cyc(600);
        load_cfg(8'h02); sys_rst_n = 1'b1; cyc(300);
        load_cfg(8'h00); sys_rst_n = 1'b1; cyc(100);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule